// File: doc/BRIEF.md
# Seeded Pseudo-Random Test Source for Four Receive Inputs

This block produces deterministic pseudo-random samples that can stand in for any of four receive input buses. It is used for debug, bench evaluation and built-in self test of the downstream channel path. Each of the four lanes owns a 23-bit shift register with feedback. All four lanes use the same feedback taps, and each lane has its own hard-wired starting value. A sync strobe from an external free-running counter reloads every register with its starting value. From that point the noise sequence, and any checksum that downstream logic builds over it, is known in advance.

Each lane has a test-select bit that picks what reaches its output: the real receive sample or the top bits of its generator. The choice passes through an output register, so both paths have one cycle of latency. Each lane is a small two-phase machine. It is in the LOAD phase when reset or sync is active and takes its seed. It is in the RUN phase on every other cycle and advances one step. The transitions are: LOAD to RUN when sync drops, RUN to LOAD when sync or reset rises, and LOAD to LOAD while sync stays high.

Top module: `test_noise_gen`

## Requirements
- R1: While reset is high at a rising edge, every output bus is zero after that edge, and every generator register holds its lane seed.
- R2: When neither reset nor sync is high at an edge, each register r advances to {r[21:0], r[22] ^ r[5]}. Bit 0 receives the XOR of bits 22 and 5, and the rest shift toward the MSB.
- R3: Sync high at an edge loads every register with its seed. If sync stays high on further edges, the register stays at the seed.
- R4: The lane seeds, written as 23-bit hex values, are 0x400010 for lane a, 0x26E6CE for lane b, 0x6EA298 for lane c and 0x0B1EB7 for lane d.
- R5: With the select bit of a lane high at edge k, that lane's output after edge k equals bits [22:23-SAMPLE_W] of its register as they stood before edge k.
- R6: With the select bit of a lane low at edge k, that lane's output after edge k equals its receive input as sampled at edge k.
- R7: The select bits act per lane. The select bit of one lane has no effect on any other lane's output or register sequence. Bit 0 selects lane a, bit 1 lane b, bit 2 lane c and bit 3 lane d.
- R8: Two sync events produce identical output sequences for the same select pattern that follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_strobe | input | 1 | Reload strobe from the external channel counter |
| test_sel | input | 4 | Per-lane test select, bit 0 for lane a through bit 3 for lane d |
| rx_in_a | input | SAMPLE_W | Receive sample, lane a |
| rx_in_b | input | SAMPLE_W | Receive sample, lane b |
| rx_in_c | input | SAMPLE_W | Receive sample, lane c |
| rx_in_d | input | SAMPLE_W | Receive sample, lane d |
| smp_out_a | output | SAMPLE_W | Sample sent downstream, lane a |
| smp_out_b | output | SAMPLE_W | Sample sent downstream, lane b |
| smp_out_c | output | SAMPLE_W | Sample sent downstream, lane c |
| smp_out_d | output | SAMPLE_W | Sample sent downstream, lane d |

## Verification
The bench builds two copies of the block from the same stimulus. The first copy uses SAMPLE_W = 23, so each output shows the whole register and every step of the feedback rule can be compared bit for bit over several hundred cycles per lane. The second copy uses SAMPLE_W = 8 and confirms that only the top bits appear and the passthrough keeps the narrow width. Between them the bench covers all 16 select patterns, held and single-cycle sync, and reset in the middle of a run.

// File: rtl/test_noise_gen_pkg.sv
package test_noise_gen_pkg;

    localparam int LFSR_W    = 23;
    localparam int NUM_LANES = 4;
    localparam int TAP_HI    = 22;
    localparam int TAP_LO    = 5;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } lane_phase_e;

    function automatic lfsr_t lane_seed(input int lane);
        lfsr_t s;
        unique case (lane)
            0:       s = 23'h400010;
            1:       s = 23'h26E6CE;
            2:       s = 23'h6EA298;
            default: s = 23'h0B1EB7;
        endcase
        return s;
    endfunction

    function automatic lfsr_t lfsr_next(input lfsr_t cur);
        return {cur[LFSR_W-2:0], cur[TAP_HI] ^ cur[TAP_LO]};
    endfunction

endpackage

// File: rtl/tng_lfsr_lane.sv
module tng_lfsr_lane
    import test_noise_gen_pkg::*;
#(
    parameter lfsr_t SEED = 23'h400010
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_strobe,
    output lfsr_t state_q
);

    lane_phase_e phase;

    always_comb begin
        if (rst || sync_strobe) phase = PH_LOAD;
        else                    phase = PH_RUN;
    end

    always_ff @(posedge clk) begin
        unique case (phase)
            PH_LOAD: state_q <= SEED;
            PH_RUN:  state_q <= lfsr_next(state_q);
            default: state_q <= SEED;
        endcase
    end

endmodule

// File: rtl/tng_out_mux.sv
module tng_out_mux #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_gen,
    input  logic [SAMPLE_W-1:0] rx_sample,
    input  logic [SAMPLE_W-1:0] gen_sample,
    output logic [SAMPLE_W-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst)          out_q <= '0;
        else if (sel_gen) out_q <= gen_sample;
        else              out_q <= rx_sample;
    end

endmodule

// File: rtl/test_noise_gen.sv
module test_noise_gen
    import test_noise_gen_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_strobe,
    input  logic [3:0]          test_sel,
    input  logic [SAMPLE_W-1:0] rx_in_a,
    input  logic [SAMPLE_W-1:0] rx_in_b,
    input  logic [SAMPLE_W-1:0] rx_in_c,
    input  logic [SAMPLE_W-1:0] rx_in_d,
    output logic [SAMPLE_W-1:0] smp_out_a,
    output logic [SAMPLE_W-1:0] smp_out_b,
    output logic [SAMPLE_W-1:0] smp_out_c,
    output logic [SAMPLE_W-1:0] smp_out_d
);

    localparam int TOP_BIT = LFSR_W - 1;

    initial begin
        if (SAMPLE_W < 1 || SAMPLE_W > LFSR_W)
            $error("SAMPLE_W must lie in 1..%0d", LFSR_W);
    end

    lfsr_t               lane_state [NUM_LANES];
    logic [SAMPLE_W-1:0] rx_arr     [NUM_LANES];
    logic [SAMPLE_W-1:0] out_arr    [NUM_LANES];

    assign rx_arr[0] = rx_in_a;
    assign rx_arr[1] = rx_in_b;
    assign rx_arr[2] = rx_in_c;
    assign rx_arr[3] = rx_in_d;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        tng_lfsr_lane #(
            .SEED (lane_seed(g))
        ) lane_i (
            .clk         (clk),
            .rst         (rst),
            .sync_strobe (sync_strobe),
            .state_q     (lane_state[g])
        );

        tng_out_mux #(
            .SAMPLE_W (SAMPLE_W)
        ) mux_i (
            .clk        (clk),
            .rst        (rst),
            .sel_gen    (test_sel[g]),
            .rx_sample  (rx_arr[g]),
            .gen_sample (lane_state[g][TOP_BIT -: SAMPLE_W]),
            .out_q      (out_arr[g])
        );
    end

    assign smp_out_a = out_arr[0];
    assign smp_out_b = out_arr[1];
    assign smp_out_c = out_arr[2];
    assign smp_out_d = out_arr[3];

endmodule

module test_noise_gen_chk
    import test_noise_gen_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                sync_strobe,
    input logic [3:0]          test_sel,
    input logic [SAMPLE_W-1:0] rx_in_a,
    input logic [SAMPLE_W-1:0] rx_in_b,
    input logic [SAMPLE_W-1:0] rx_in_c,
    input logic [SAMPLE_W-1:0] rx_in_d,
    input logic [SAMPLE_W-1:0] smp_out_a,
    input logic [SAMPLE_W-1:0] smp_out_b,
    input logic [SAMPLE_W-1:0] smp_out_c,
    input logic [SAMPLE_W-1:0] smp_out_d
);

    logic [SAMPLE_W-1:0] rx_c  [NUM_LANES];
    logic [SAMPLE_W-1:0] out_c [NUM_LANES];

    assign rx_c[0]  = rx_in_a;
    assign rx_c[1]  = rx_in_b;
    assign rx_c[2]  = rx_in_c;
    assign rx_c[3]  = rx_in_d;
    assign out_c[0] = smp_out_a;
    assign out_c[1] = smp_out_b;
    assign out_c[2] = smp_out_c;
    assign out_c[3] = smp_out_d;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        localparam lfsr_t SEED_G = lane_seed(g);

        // R1
        reset_zero_chk: assert property (@(posedge clk)
            rst |=> out_c[g] == '0);

        // R6
        passthru_chk: assert property (@(posedge clk) disable iff (rst)
            !test_sel[g] |=> out_c[g] == $past(rx_c[g]));

        // R3 R4 R5
        seed_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
            (sync_strobe ##1 test_sel[g]) |=> out_c[g] == SEED_G[LFSR_W-1 -: SAMPLE_W]);

        if (SAMPLE_W == LFSR_W) begin : g_full
            // R2
            step_rule_chk: assert property (@(posedge clk) disable iff (rst)
                (test_sel[g] && !sync_strobe) ##1 test_sel[g]
                |=> out_c[g] == SAMPLE_W'(lfsr_next(lfsr_t'($past(out_c[g])))));
        end
    end

endmodule

bind test_noise_gen test_noise_gen_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sync_strobe (sync_strobe),
    .test_sel    (test_sel),
    .rx_in_a     (rx_in_a),
    .rx_in_b     (rx_in_b),
    .rx_in_c     (rx_in_c),
    .rx_in_d     (rx_in_d),
    .smp_out_a   (smp_out_a),
    .smp_out_b   (smp_out_b),
    .smp_out_c   (smp_out_c),
    .smp_out_d   (smp_out_d)
);

// File: tb/test_noise_gen_tb_top.sv
module test_noise_gen_tb_top;

    localparam int W_FULL = 23;
    localparam int W_NAR  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sync_strobe = 1'b0;
    logic [3:0]        test_sel = 4'h0;
    logic [W_FULL-1:0] rx [4];
    logic [W_FULL-1:0] of [4];
    logic [W_NAR-1:0]  on [4];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [22:0] model [4];
    logic [22:0] seeds [4];
    logic [22:0] rec   [64];

    always #4 clk = ~clk;

    initial begin
        for (int p = 0; p < 4; p++) rx[p] = '0;
    end

    test_noise_gen #(.SAMPLE_W(W_FULL)) dut_i (
        .clk(clk), .rst(rst), .sync_strobe(sync_strobe), .test_sel(test_sel),
        .rx_in_a(rx[0]), .rx_in_b(rx[1]), .rx_in_c(rx[2]), .rx_in_d(rx[3]),
        .smp_out_a(of[0]), .smp_out_b(of[1]), .smp_out_c(of[2]), .smp_out_d(of[3])
    );

    test_noise_gen #(.SAMPLE_W(W_NAR)) dut_n8 (
        .clk(clk), .rst(rst), .sync_strobe(sync_strobe), .test_sel(test_sel),
        .rx_in_a(rx[0][W_NAR-1:0]), .rx_in_b(rx[1][W_NAR-1:0]),
        .rx_in_c(rx[2][W_NAR-1:0]), .rx_in_d(rx[3][W_NAR-1:0]),
        .smp_out_a(on[0]), .smp_out_b(on[1]), .smp_out_c(on[2]), .smp_out_d(on[3])
    );

    function automatic logic [22:0] adv(input logic [22:0] r);
        return {r[21:0], r[22] ^ r[5]};
    endfunction

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual 0x%06h expected 0x%06h", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // one clock: drive at negedge, predict, then compare after the edge
    task automatic tick(input logic r, input logic s, input logic [3:0] en, input string req);
        logic [22:0] ef [4];
        logic [7:0]  en8 [4];
        rst = r;
        sync_strobe = s;
        test_sel = en;
        for (int p = 0; p < 4; p++) begin
            rx[p] = 23'(cyc * 7919 + p * 104729) ^ 23'(cyc << (p + 3));
            if (r) begin
                ef[p] = '0;
            end else begin
                ef[p] = en[p] ? model[p] : rx[p];
            end
            en8[p] = r ? 8'h00 : (en[p] ? model[p][22:15] : rx[p][7:0]);
            model[p] = (r || s) ? seeds[p] : adv(model[p]);
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        for (int p = 0; p < 4; p++) begin
            check(req, of[p], ef[p]);
            check({req, " narrow"}, 23'(on[p]), 23'(en8[p]));
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        seeds[0] = 23'h400010;
        seeds[1] = 23'h26E6CE;
        seeds[2] = 23'h6EA298;
        seeds[3] = 23'h0B1EB7;
        for (int p = 0; p < 4; p++) model[p] = seeds[p];
        @(negedge clk);

        // R1: reset clears outputs and seeds the registers
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 4'hF, "R1");

        // R6: passthrough on all lanes, registers keep running from the reset seed
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b0, 4'h0, "R6");

        // R2 R5: long generator run on all lanes
        for (int i = 0; i < 400; i++) tick(1'b0, 1'b0, 4'hF, "R2");

        // R3 R4: single sync, then the seed must show on the output
        tick(1'b0, 1'b1, 4'hF, "R3");
        tick(1'b0, 1'b0, 4'hF, "R4");
        check("R4 lane a", of[0], 23'h400010);
        check("R4 lane b", of[1], 23'h26E6CE);
        check("R4 lane c", of[2], 23'h6EA298);
        check("R4 lane d", of[3], 23'h0B1EB7);
        for (int i = 0; i < 62; i++) begin
            rec[i] = of[0];
            tick(1'b0, 1'b0, 4'hF, "R5");
        end

        // R3: held sync keeps the seed
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 4'hF, "R3 held");
        for (int i = 0; i < 4; i++) check("R3 held", of[i], seeds[i]);

        // R7: every select pattern
        for (int m = 0; m < 16; m++)
            for (int i = 0; i < 12; i++) tick(1'b0, (i == 0) && m[0], 4'(m), "R7");

        // R8: second sync reproduces the recorded sequence of lane a
        tick(1'b0, 1'b1, 4'hF, "R8");
        tick(1'b0, 1'b0, 4'hF, "R8");
        for (int i = 0; i < 62; i++) begin
            check("R8", of[0], rec[i]);
            tick(1'b0, 1'b0, 4'hF, "R8");
        end

        // R1: reset in the middle of a run
        tick(1'b1, 1'b0, 4'hA, "R1 mid");
        for (int i = 0; i < 4; i++) check("R1 mid", of[i], 23'h0);
        for (int i = 0; i < 30; i++) tick(1'b0, 1'b0, 4'h5, "R7");

        finish_run();
    end

endmodule